// File: doc/BRIEF.md
# Clock Stop and Sleep Controller

This block decides which clock domains of a processor bus interface may run, and whether snoops and interrupts may be taken, as the interface moves through its low-power states. Two active-low requests drive it from outside: a stop-clock request and a sleep request. A one-cycle or level "grant done" input stands in for the bus acknowledge that ends the entry into the stop-grant state. All request inputs pass through a parameterised synchroniser before they reach the state machine.

There are four states. Running and stop-pending keep every clock on. Stop-grant halts the core clock but keeps the bus-unit and interrupt-controller clocks running. Sleep halts everything except the PLL. Sleep can only be reached from stop-grant. Releasing sleep always returns to stop-grant, never straight to running. The current state is driven on a status output.

Top module: `pwr_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, the state output reads running (2'b00) and all six enables (core, bus, interrupt-controller, snoop, interrupt, PLL) are 1. The PLL enable is 1 in every state.
- R2: In running, an asserted stop request (stop_req_n = 0) moves the state to stop-pending (2'b01). In stop-pending, grant_done = 1 with the stop request still asserted moves it to stop-grant (2'b10). Both running and stop-pending drive all enables to 1.
- R3: A released stop request (stop_req_n = 1) in stop-pending or in stop-grant returns the state to running, unless R6 applies.
- R4: In stop-grant, core_clk_en is 0. bus_clk_en, intc_clk_en, snoop_en, intr_en and pll_en are 1.
- R5: An asserted sleep request (sleep_req_n = 0) in running or stop-pending has no effect on the state or the enables.
- R6: In stop-grant, an asserted sleep request moves the state to sleep (2'b11). It takes precedence over a stop release in the same cycle. Sleep is entered from no other state.
- R7: In sleep, core_clk_en, bus_clk_en, intc_clk_en, snoop_en and intr_en are 0, and pll_en is 1.
- R8: In sleep, grant_done and stop_req_n have no effect while the sleep request stays asserted.
- R9: A released sleep request in sleep moves the state to stop-grant, whatever the stop request is doing. This re-enables the bus and interrupt-controller clocks.
- R10: Each request input passes through SYNC_STAGES flip-flops. A change applied before a clock edge therefore changes the state at edge SYNC_STAGES+1, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Active-low stop-clock request |
| sleep_req_n | input | 1 | Active-low sleep request |
| grant_done | input | 1 | Stop-grant acknowledge finished |
| core_clk_en | output | 1 | Core clock gate enable |
| bus_clk_en | output | 1 | Bus-unit clock gate enable |
| intc_clk_en | output | 1 | Interrupt-controller clock gate enable |
| snoop_en | output | 1 | Snoop acceptance enable |
| intr_en | output | 1 | Interrupt acceptance enable |
| pll_en | output | 1 | PLL keep-running enable |
| state_o | output | 2 | Current state encoding |

## Verification
The bench first brings the block into each of its four states. In each state it applies all eight combinations of stop request, sleep request and grant_done at the same moment. This separates the priority between sleep and stop release in stop-grant, and shows which inputs are ignored in running, stop-pending and sleep. It also shows that waking always lands in stop-grant. For every combination the state is sampled one cycle before and exactly at the synchroniser-plus-register latency, which pins the pipeline depth. The enables are then compared against the values expected for the resulting state.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

   typedef enum logic [1:0] {
      PS_RUN   = 2'b00,
      PS_PEND  = 2'b01,
      PS_GRANT = 2'b10,
      PS_SLEEP = 2'b11
   } pwr_state_e;

   typedef struct packed {
      logic core;
      logic bus;
      logic intc;
      logic snoop;
      logic intr;
      logic pll;
   } clk_en_t;

   localparam int unsigned STATE_W = $bits(pwr_state_e);
   localparam int unsigned EN_W    = $bits(clk_en_t);

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES > 8) begin : g_bad_depth
      $error("pwr_sync: STAGES must not exceed 8");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else if (STAGES == 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= {STAGES{RST_VAL}};
         else        sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
   import pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_act,
   input  logic       sleep_act,
   input  logic       grant_done,
   output pwr_state_e state
);

   pwr_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         PS_RUN: begin
            if (stop_act) nxt = PS_PEND;
         end
         PS_PEND: begin
            if (!stop_act)      nxt = PS_RUN;
            else if (grant_done) nxt = PS_GRANT;
         end
         PS_GRANT: begin
            if (sleep_act)      nxt = PS_SLEEP;
            else if (!stop_act) nxt = PS_RUN;
         end
         PS_SLEEP: begin
            if (!sleep_act) nxt = PS_GRANT;
         end
         default: nxt = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_RUN;
      else        state <= nxt;
   end

endmodule

// File: rtl/pwr_outdec.sv
module pwr_outdec
   import pwr_pkg::*;
(
   input  pwr_state_e state,
   output clk_en_t    en
);

   always_comb begin
      en = '{core: 1'b1, bus: 1'b1, intc: 1'b1, snoop: 1'b1, intr: 1'b1, pll: 1'b1};
      unique case (state)
         PS_RUN, PS_PEND: ;
         PS_GRANT: en.core = 1'b0;
         PS_SLEEP: begin
            en.core  = 1'b0;
            en.bus   = 1'b0;
            en.intc  = 1'b0;
            en.snoop = 1'b0;
            en.intr  = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
   import pwr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stop_req_n,
   input  logic               sleep_req_n,
   input  logic               grant_done,
   output logic               core_clk_en,
   output logic               bus_clk_en,
   output logic               intc_clk_en,
   output logic               snoop_en,
   output logic               intr_en,
   output logic               pll_en,
   output logic [STATE_W-1:0] state_o
);

   localparam int unsigned N_IN = 3;

   logic [N_IN-1:0] raw_in;
   logic [N_IN-1:0] sync_in;
   localparam logic [N_IN-1:0] IN_RST = 3'b011;

   assign raw_in = {grant_done, sleep_req_n, stop_req_n};

   for (genvar i = 0; i < N_IN; i++) begin : g_sync
      pwr_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (IN_RST[i])
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw_in[i]),
         .q     (sync_in[i])
      );
   end

   pwr_state_e state;
   clk_en_t    en;

   pwr_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_act   (~sync_in[0]),
      .sleep_act  (~sync_in[1]),
      .grant_done (sync_in[2]),
      .state      (state)
   );

   pwr_outdec u_dec (
      .state (state),
      .en    (en)
   );

   assign core_clk_en = en.core;
   assign bus_clk_en  = en.bus;
   assign intc_clk_en = en.intc;
   assign snoop_en    = en.snoop;
   assign intr_en     = en.intr;
   assign pll_en      = en.pll;
   assign state_o     = state;

endmodule

// File: rtl/pwr_ctrl_chk.sv
module pwr_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       core_clk_en,
   input logic       bus_clk_en,
   input logic       intc_clk_en,
   input logic       snoop_en,
   input logic       intr_en,
   input logic       pll_en,
   input logic [1:0] state_o
);

   a_r1_pll_always_on: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en);

   a_r2_active_all_on: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 || state_o == 2'b01) |->
         (core_clk_en && bus_clk_en && intc_clk_en && snoop_en && intr_en));

   a_r2_grant_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b10 && $past(state_o) != 2'b10) |->
         ($past(state_o) == 2'b01 || $past(state_o) == 2'b11));

   a_r4_grant_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b10) |->
         (!core_clk_en && bus_clk_en && intc_clk_en && snoop_en && intr_en));

   a_r6_sleep_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11 && $past(state_o) != 2'b11) |-> ($past(state_o) == 2'b10));

   a_r7_sleep_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11) |->
         (!core_clk_en && !bus_clk_en && !intc_clk_en && !snoop_en && !intr_en && pll_en));

   a_r9_wake_to_grant: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == 2'b11 && state_o != 2'b11) |-> (state_o == 2'b10));

endmodule

bind pwr_ctrl pwr_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_clk_en (core_clk_en),
   .bus_clk_en  (bus_clk_en),
   .intc_clk_en (intc_clk_en),
   .snoop_en    (snoop_en),
   .intr_en     (intr_en),
   .pll_en      (pll_en),
   .state_o     (state_o)
);

// File: tb/tb_pwr_ctrl.sv
module tb_pwr_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int LAT        = SYNC + 1;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req_n = 1'b1;
   logic       sleep_req_n = 1'b1;
   logic       grant_done = 1'b0;
   logic       core_clk_en, bus_clk_en, intc_clk_en, snoop_en, intr_en, pll_en;
   logic [1:0] state_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_ctrl #(.SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n),
      .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n), .grant_done(grant_done),
      .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .intc_clk_en(intc_clk_en),
      .snoop_en(snoop_en), .intr_en(intr_en), .pll_en(pll_en), .state_o(state_o)
   );

   // state codes: 0 running, 1 stop-pending, 2 stop-grant, 3 sleep
   function automatic logic [1:0] ref_next(input logic [1:0] s, input logic stp_n,
                                           input logic slp_n, input logic gd);
      case (s)
         2'd0: ref_next = stp_n ? 2'd0 : 2'd1;
         2'd1: ref_next = stp_n ? 2'd0 : (gd ? 2'd2 : 2'd1);
         2'd2: ref_next = !slp_n ? 2'd3 : (stp_n ? 2'd0 : 2'd2);
         default: ref_next = slp_n ? 2'd2 : 2'd3;
      endcase
   endfunction

   // order {core, bus, intc, snoop, intr, pll}
   function automatic logic [5:0] ref_en(input logic [1:0] s);
      case (s)
         2'd0, 2'd1: ref_en = 6'b111111;
         2'd2:       ref_en = 6'b011111;
         default:    ref_en = 6'b000001;
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] s, input logic stp_n,
                                    input logic slp_n, input logic gd);
      case (s)
         2'd0: tag_of = !stp_n ? "R2" : "R5";
         2'd1: tag_of = stp_n ? "R3" : (gd ? "R2" : "R5");
         2'd2: tag_of = !slp_n ? "R6" : (stp_n ? "R3" : "R4");
         default: tag_of = slp_n ? "R9" : "R8";
      endcase
   endfunction

   function automatic string en_tag(input logic [1:0] s);
      case (s)
         2'd0, 2'd1: en_tag = "R2";
         2'd2:       en_tag = "R4";
         default:    en_tag = "R7";
      endcase
   endfunction

   task automatic check_state(input logic [1:0] exp, input string tag);
      checks++;
      if (state_o !== exp) begin
         failures++;
         $display("FAIL %s state actual=%0d expected=%0d", tag, state_o, exp);
      end
   endtask

   task automatic check_en(input logic [5:0] exp, input string tag);
      logic [5:0] act;
      act = {core_clk_en, bus_clk_en, intc_clk_en, snoop_en, intr_en, pll_en};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s enables actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic go_to(input logic [1:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      stop_req_n = 1'b1; sleep_req_n = 1'b1; grant_done = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      if (s != 2'd0) stop_req_n = 1'b0;
      repeat (LAT + 2) @(negedge clk);
      if (s >= 2'd2) begin
         grant_done = 1'b1;
         repeat (LAT + 2) @(negedge clk);
      end
      if (s == 2'd3) begin
         sleep_req_n = 1'b0;
         repeat (LAT + 2) @(negedge clk);
      end
      check_state(s, (s == 2'd3) ? "R6" : "R2");
   endtask

   initial begin
      // R1: reset values, during reset and right after release
      repeat (2) @(negedge clk);
      check_state(2'd0, "R1");
      check_en(6'b111111, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_state(2'd0, "R1");
      check_en(6'b111111, "R1");

      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 8; c++) begin
            logic [1:0] nx;
            go_to(2'(s));
            stop_req_n  = c[0];
            sleep_req_n = c[1];
            grant_done  = c[2];
            nx = ref_next(2'(s), c[0], c[1], c[2]);
            // R10: no change before the synchroniser plus state register latency
            repeat (LAT - 1) @(negedge clk);
            check_state(2'(s), "R10");
            @(negedge clk);
            check_state(nx, tag_of(2'(s), c[0], c[1], c[2]));
            check_en(ref_en(nx), en_tag(nx));
            if (pll_en !== 1'b1) begin
               failures++;
               $display("FAIL R1 pll_en actual=%b expected=1", pll_en);
            end
            checks++;
         end
      end

      // R9: wake with stop released passes through stop-grant before running
      go_to(2'd3);
      stop_req_n  = 1'b1;
      sleep_req_n = 1'b1;
      repeat (LAT) @(negedge clk);
      check_state(2'd2, "R9");
      check_en(6'b011111, "R9");
      @(negedge clk);
      check_state(2'd0, "R3");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule